// File: doc/BRIEF.md
# Streaming Gaussian Component Scorer

This block turns a stream of fixed-point operand beats into the log-domain score of one multivariate Gaussian mixture component. A component is sent as one beat per dimension and then one closing beat. A dimension beat carries a feature value, a mean and an inverse-variance factor. The closing beat carries the component's scaling constant K and its log mixture weight W. The block squares the difference between feature and mean and scales it by the factor. It sums these terms over all dimensions with saturation. It then presents `K - sum + W`, saturated to 32 bits, together with a single-cycle valid strobe.

The pipeline has no sequencing state machine. The start and end flags that travel with each beat choose how every stage treats that beat. Each stage forwards a valid bit, and a stage whose input is not valid keeps its registers unchanged. A gap in the input stream therefore stalls the pipe locally, and an empty pipe stops updating altogether. Seven arithmetic stages plus three padding stages give a fixed ten-cycle latency, which lines up with a downstream accumulation stage of the same depth. A dimension term is `((X - M)^2 * F) >>> FRAC_SHIFT`, where FRAC_SHIFT defaults to 8.

Top module: `gauss_dist_pipe`

## Requirements
- R1: A beat with in_go=1, in_last=0 is a dimension beat: in_a is the feature, in_b the mean and in_c the factor. in_first=1 marks the first dimension of a component. A beat with in_go=1, in_last=1 closes the component: in_a is K, in_b is W, and in_c has no effect on the result. in_first and in_last are never both 1.
- R2: Each dimension contributes the term ((X-M)^2 * F) >>> FRAC_SHIFT. The shift is arithmetic, so a negative product rounds toward minus infinity. The term is then saturated to signed 32 bits.
- R3: The score is sat32(sat32(K - S) + W). S is the running saturating sum of the component's terms.
- R4: out_valid is high for exactly one cycle per component. It rises 10 clock cycles after the clock edge that samples the closing beat.
- R5: A beat with in_first=1 restarts the sum, so the sum of an earlier component has no effect on the next score.
- R6: Idle cycles (in_go=0) inserted between the beats of a component leave its score unchanged.
- R7: out_score keeps the last score presented while the pipe is idle and while the dimension beats of a later component flow through.
- R8: Every intermediate result saturates at 2147483647 or -2147483648 instead of wrapping. This covers the scaled term, the sum, K-S and the final addition.
- R9: After a closing beat the feeder leaves exactly one or more idle cycles before the next component. When a component follows with that one-cycle gap, both scores appear in order, each 10 cycles after its own closing beat.
- R10: While rst is high, and after it is released until the first score, out_valid=0 and out_score=0. A component cut off by reset produces no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_go | input | 1 | Beat present on the input lanes |
| in_first | input | 1 | Beat is the first dimension of a component |
| in_last | input | 1 | Beat is the closing K/W beat |
| in_a | input | 16 | Feature value, or K on the closing beat (signed) |
| in_b | input | 16 | Mean, or W on the closing beat (signed) |
| in_c | input | 16 | Inverse-variance factor (signed); unused on the closing beat |
| out_valid | output | 1 | Score strobe, one cycle per component |
| out_score | output | 32 | Component score (signed) |

## Verification
The hardest case to reach from the ports is the hand-over between two components sent with only the one mandatory idle cycle between them. In that case the first beat of the second component clears the sum just as the closing beat of the first component reads it. The stimulus sends two table components in this way and checks that each score arrives at its own cycle with its own value. A second hard case is saturation inside the sum rather than at the output. Lanes at full scale with a negative factor drive the sum to the negative rail, and K minus that sum then clamps at the positive rail before W is added.

// File: rtl/gdp_pkg.sv
package gdp_pkg;

    localparam int DATA_W     = 16;
    localparam int ACC_W      = 32;
    localparam int WIDE_W     = 2 * ACC_W;
    localparam int CORE_DEPTH = 7;
    localparam int PAD_DEPTH  = 3;
    localparam int LATENCY    = CORE_DEPTH + PAD_DEPTH;

    typedef logic signed [DATA_W-1:0] lane_t;
    typedef logic signed [ACC_W-1:0]  acc_t;
    typedef logic signed [WIDE_W-1:0] wide_t;

    localparam acc_t ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam acc_t ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    // beat inside the front stages: x is the working value, y the second lane, z the factor
    typedef struct packed {
        logic  first;
        logic  last;
        wide_t x;
        lane_t y;
        lane_t z;
    } beat_t;

    // beat handed to the summing stages once the factor has been consumed
    typedef struct packed {
        logic  first;
        logic  last;
        wide_t x;
        lane_t y;
    } tail_t;

    function automatic acc_t sat_acc(input wide_t v);
        if (v > wide_t'(ACC_MAX))
            return ACC_MAX;
        else if (v < wide_t'(ACC_MIN))
            return ACC_MIN;
        else
            return acc_t'(v);
    endfunction

    function automatic wide_t widen(input acc_t v);
        return wide_t'(v);
    endfunction

endpackage

// File: rtl/gdp_front.sv
module gdp_front
    import gdp_pkg::*;
#(
    parameter int FRAC_SHIFT = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  in_go,
    input  logic  in_first,
    input  logic  in_last,
    input  lane_t in_a,
    input  lane_t in_b,
    input  lane_t in_c,
    output logic  out_valid,
    output tail_t out_tail
);

    beat_t s1, s2, s3;
    logic  v1, v2, v3;
    tail_t s4;
    logic  v4;

    wide_t prod, scaled, term;

    // stage 1: capture lanes
    always_ff @(posedge clk) begin
        if (rst) begin
            v1 <= 1'b0;
            s1 <= '0;
        end else begin
            v1 <= in_go;
            if (in_go) begin
                s1.first <= in_first;
                s1.last  <= in_last;
                s1.x     <= wide_t'(in_a);
                s1.y     <= in_b;
                s1.z     <= in_c;
            end
        end
    end

    // stage 2: difference for dimension beats, K/W pass through
    always_ff @(posedge clk) begin
        if (rst) begin
            v2 <= 1'b0;
            s2 <= '0;
        end else begin
            v2 <= v1;
            if (v1) begin
                s2 <= s1;
                if (!s1.last)
                    s2.x <= s1.x - wide_t'(s1.y);
            end
        end
    end

    // stage 3: square
    always_ff @(posedge clk) begin
        if (rst) begin
            v3 <= 1'b0;
            s3 <= '0;
        end else begin
            v3 <= v2;
            if (v2) begin
                s3 <= s2;
                if (!s2.last)
                    s3.x <= s2.x * s2.x;
            end
        end
    end

    // stage 4: scale by the factor, rescale, clamp
    always_comb begin
        prod   = s3.x * wide_t'(s3.z);
        scaled = prod >>> FRAC_SHIFT;
        term   = widen(sat_acc(scaled));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v4 <= 1'b0;
            s4 <= '0;
        end else begin
            v4 <= v3;
            if (v3) begin
                s4.first <= s3.first;
                s4.last  <= s3.last;
                s4.y     <= s3.y;
                s4.x     <= s3.last ? s3.x : term;
            end
        end
    end

    assign out_valid = v4;
    assign out_tail  = s4;

    // a square scaled by a non-negative factor never yields a negative term
    AST_TERM_SIGN: assert property (@(posedge clk) disable iff (rst)
        (v4 && !s4.last && ($past(s3.z) >= 0)) |-> (s4.x >= 0)); // R2

endmodule

// File: rtl/gdp_accum.sv
module gdp_accum
    import gdp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  tail_t in_tail,
    output logic  out_valid,
    output acc_t  out_score
);

    acc_t  acc;
    logic  v5, v6, v7;
    logic  last5, last6, last7;
    wide_t k5;
    lane_t w5, w6;
    acc_t  d6, score7;

    // stage 5: running sum; a first beat restarts it
    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            v5    <= 1'b0;
            last5 <= 1'b0;
            k5    <= '0;
            w5    <= '0;
        end else begin
            v5 <= in_valid;
            if (in_valid) begin
                last5 <= in_tail.last;
                k5    <= in_tail.x;
                w5    <= in_tail.y;
                if (!in_tail.last) begin
                    if (in_tail.first)
                        acc <= sat_acc(in_tail.x);
                    else
                        acc <= sat_acc(widen(acc) + in_tail.x);
                end
            end
        end
    end

    // stage 6: K minus the finished sum
    always_ff @(posedge clk) begin
        if (rst) begin
            v6    <= 1'b0;
            last6 <= 1'b0;
            d6    <= '0;
            w6    <= '0;
        end else begin
            v6 <= v5;
            if (v5) begin
                last6 <= last5;
                w6    <= w5;
                if (last5)
                    d6 <= sat_acc(k5 - widen(acc));
            end
        end
    end

    // stage 7: add the log weight
    always_ff @(posedge clk) begin
        if (rst) begin
            v7     <= 1'b0;
            last7  <= 1'b0;
            score7 <= '0;
        end else begin
            v7 <= v6;
            if (v6) begin
                last7 <= last6;
                if (last6)
                    score7 <= sat_acc(widen(d6) + wide_t'(w6));
            end
        end
    end

    assign out_valid = v7 && last7;
    assign out_score = score7;

endmodule

// File: rtl/gdp_delay.sv
module gdp_delay #(
    parameter int DEPTH = 3,
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_data,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_data
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        logic             v;
        logic [WIDTH-1:0] d;
        logic             v_in;
        logic [WIDTH-1:0] d_in;

        if (i == 0) begin : g_head
            assign v_in = in_valid;
            assign d_in = in_data;
        end else begin : g_link
            assign v_in = g_stage[i-1].v;
            assign d_in = g_stage[i-1].d;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                v <= 1'b0;
                d <= '0;
            end else begin
                v <= v_in;
                if (v_in)
                    d <= d_in;
            end
        end
    end

    assign out_valid = g_stage[DEPTH-1].v;
    assign out_data  = g_stage[DEPTH-1].d;

endmodule

// File: rtl/gauss_dist_pipe.sv
module gauss_dist_pipe
    import gdp_pkg::*;
#(
    parameter int FRAC_SHIFT = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_go,
    input  logic                     in_first,
    input  logic                     in_last,
    input  logic signed [DATA_W-1:0] in_a,
    input  logic signed [DATA_W-1:0] in_b,
    input  logic signed [DATA_W-1:0] in_c,
    output logic                     out_valid,
    output logic signed [ACC_W-1:0]  out_score
);

    logic       f_valid;
    tail_t      f_tail;
    logic       a_valid;
    acc_t       a_score;
    logic [ACC_W-1:0] pad_data;
    logic       seen;

    gdp_front #(.FRAC_SHIFT(FRAC_SHIFT)) u_front (
        .clk      (clk),
        .rst      (rst),
        .in_go    (in_go),
        .in_first (in_first),
        .in_last  (in_last),
        .in_a     (in_a),
        .in_b     (in_b),
        .in_c     (in_c),
        .out_valid(f_valid),
        .out_tail (f_tail)
    );

    gdp_accum u_accum (
        .clk      (clk),
        .rst      (rst),
        .in_valid (f_valid),
        .in_tail  (f_tail),
        .out_valid(a_valid),
        .out_score(a_score)
    );

    gdp_delay #(.DEPTH(PAD_DEPTH), .WIDTH(ACC_W)) u_pad (
        .clk      (clk),
        .rst      (rst),
        .in_valid (a_valid),
        .in_data  (a_score),
        .out_valid(out_valid),
        .out_data (pad_data)
    );

    assign out_score = acc_t'(pad_data);

    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    AST_FIRST_NOT_LAST: assert property (@(posedge clk) disable iff (rst)
        in_go |-> !(in_first && in_last)); // R1

    AST_GAP_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        (in_go && in_last) |=> !in_go); // R9

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid); // R4

    AST_SCORE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (seen && !out_valid) |-> $stable(out_score)); // R7

endmodule

// File: tb/tb_gauss_dist_pipe.sv
module tb_gauss_dist_pipe;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_go = 1'b0, in_first = 1'b0, in_last = 1'b0;
    logic signed [15:0] in_a = '0, in_b = '0, in_c = '0;
    logic out_valid;
    logic signed [31:0] out_score;

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    gauss_dist_pipe dut (
        .clk(clk), .rst(rst), .in_go(in_go), .in_first(in_first), .in_last(in_last),
        .in_a(in_a), .in_b(in_b), .in_c(in_c), .out_valid(out_valid), .out_score(out_score)
    );

    // table: dims, features, means, factors, K, W, expected score (FRAC_SHIFT = 8)
    localparam int NV = 5;
    localparam int TV_D [NV] = '{2, 1, 3, 4, 1};
    localparam int TV_X [NV][4] = '{'{10, -5, 0, 0}, '{100, 0, 0, 0}, '{0, 1, 2, 0},
                                   '{-3, 7, 20, -1}, '{0, 0, 0, 0}};
    localparam int TV_M [NV][4] = '{'{4, 3, 0, 0}, '{100, 0, 0, 0}, '{1, 1, 1, 0},
                                   '{0, 0, 10, 1}, '{3, 0, 0, 0}};
    localparam int TV_O [NV][4] = '{'{256, 512, 0, 0}, '{1000, 0, 0, 0}, '{300, 300, 300, 0},
                                   '{128, 64, 256, 1000}, '{-100, 0, 0, 0}};
    localparam int TV_K [NV] = '{1000, -200, 5, -10, 0};
    localparam int TV_W [NV] = '{-50, 30, 0, 7, 0};
    localparam int TV_E [NV] = '{786, -170, 3, -134, 4};

    int total = 0;
    int fails = 0;
    int nlog = 0;
    longint log_s [64];
    int     log_c [64];

    always @(negedge clk) begin
        if (out_valid && nlog < 64) begin
            log_s[nlog] = out_score;
            log_c[nlog] = cyc;
            nlog = nlog + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic beat(input logic f, input logic l, input int a, input int b, input int c);
        @(negedge clk);
        in_go = 1'b1; in_first = f; in_last = l;
        in_a = a[15:0]; in_b = b[15:0]; in_c = c[15:0];
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_go = 1'b0; in_first = 1'b0; in_last = 1'b0;
        end
    endtask

    // sends table entry i, returns the cycle count at which the closing beat was driven
    task automatic send_vec(input int i, input int stall, input int cval, output int lastc);
        for (int k = 0; k < TV_D[i]; k++) begin
            beat(k == 0, 1'b0, TV_X[i][k], TV_M[i][k], TV_O[i][k]);
            if (stall > 0) idle(stall);
        end
        beat(1'b0, 1'b1, TV_K[i], TV_W[i], cval);
        lastc = cyc;
        idle(1);
    endtask

    task automatic expect_one(input int lastc, input int nbefore, input longint exp, input string req);
        while (cyc < lastc + 12) idle(1);
        chk(nlog == nbefore + 1, "R4 one pulse per component", nlog - nbefore, 1);
        if (nlog > nbefore) begin
            chk(log_c[nbefore] == lastc + 10, "R4 latency", log_c[nbefore] - lastc, 10);
            chk(log_s[nbefore] == exp, req, log_s[nbefore], exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int lc, lc2, nb;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R10 valid in reset", out_valid, 0);
        chk(out_score == 0, "R10 score in reset", out_score, 0);
        @(negedge clk); rst = 1'b0;
        idle(2);
        chk(out_valid == 1'b0 && out_score == 0, "R10 after release", out_score, 0);

        // table walk: R1 lanes, R2 terms (entry 4 has a negative factor), R3 score, R5 restart (entry 1)
        for (int i = 0; i < NV; i++) begin
            nb = nlog;
            send_vec(i, 0, 123, lc);
            expect_one(lc, nb, TV_E[i], (i == 1) ? "R5 sum restarts" : (i == 4) ? "R2 arithmetic shift" : "R3 score");
        end

        // R6: idle cycles between beats
        nb = nlog;
        send_vec(0, 2, 123, lc);
        expect_one(lc, nb, 786, "R6 stalled beats");

        // R1: factor lane on the closing beat has no effect
        nb = nlog;
        send_vec(0, 0, -777, lc);
        expect_one(lc, nb, 786, "R1 c lane ignored on closing beat");

        // R7: hold while idle and while a later component's beats flow
        idle(6);
        chk(out_valid == 1'b0 && out_score == 786, "R7 hold idle", out_score, 786);
        nb = nlog;
        for (int k = 0; k < TV_D[3]; k++) begin
            beat(k == 0, 1'b0, TV_X[3][k], TV_M[3][k], TV_O[3][k]);
            chk(out_score == 786, "R7 hold during beats", out_score, 786);
        end
        beat(1'b0, 1'b1, TV_K[3], TV_W[3], 0);
        lc = cyc;
        idle(1);
        chk(out_score == 786, "R7 hold before result", out_score, 786);
        expect_one(lc, nb, -134, "R3 score after hold");

        // R8: saturation at the negative rail
        nb = nlog;
        beat(1'b1, 1'b0, 32767, -32768, 32767);
        beat(1'b0, 1'b1, -32768, -100, 0);
        lc = cyc; idle(1);
        expect_one(lc, nb, -64'sd2147483648, "R8 negative rail");

        // R8: saturated sum, K-S clamps high, then W applied
        nb = nlog;
        beat(1'b1, 1'b0, 32767, -32768, -32768);
        beat(1'b0, 1'b0, 32767, -32768, -32768);
        beat(1'b0, 1'b1, 10, -1, 0);
        lc = cyc; idle(1);
        expect_one(lc, nb, 64'sd2147483646, "R8 inner clamp");

        // R9: two components with the minimum one-cycle gap
        nb = nlog;
        send_vec(1, 0, 0, lc);
        send_vec(2, 0, 0, lc2);
        while (cyc < lc2 + 12) idle(1);
        chk(nlog == nb + 2, "R9 two results", nlog - nb, 2);
        if (nlog >= nb + 2) begin
            chk(log_c[nb] == lc + 10 && log_s[nb] == -170, "R9 first result", log_s[nb], -170);
            chk(log_c[nb+1] == lc2 + 10 && log_s[nb+1] == 3, "R9 second result", log_s[nb+1], 3);
        end

        // R10: reset in the middle of a component
        nb = nlog;
        beat(1'b1, 1'b0, 50, 0, 256);
        beat(1'b0, 1'b0, 50, 0, 256);
        @(negedge clk); in_go = 1'b0; rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle(12);
        chk(nlog == nb, "R10 no output from cut component", nlog - nb, 0);
        chk(out_score == 0, "R10 score cleared", out_score, 0);
        nb = nlog;
        send_vec(1, 0, 0, lc);
        expect_one(lc, nb, -170, "R10 clean start after reset");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule